// File: doc/BRIEF.md
# DRAM Distributed Refresh Scheduler

This block keeps a DRAM array alive by spreading refresh cycles evenly over time instead of issuing them in a burst. An interval timer fires once every `INTERVAL` clock cycles. Each firing adds one refresh to a pending count. The block shares the memory between that pending work and a single host requester. A host access that is already running is never cut short. When it ends, every pending refresh is served before the next host access.

A mode input picks how each refresh is addressed. In row-driven mode the block puts its own row counter on the row address lines, and the counter steps through every row in order. In command-only mode the block raises a refresh command and leaves the row lines undriven, because the device steps its own internal row count. Each refresh occupies the memory for a fixed `REF_LEN` cycles. No column address or data takes part in a refresh. The default `INTERVAL` of 780 cycles covers 8192 rows in 64 ms at a 100 MHz clock.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset and directly after it, `ref_busy`, `host_gnt`, `ref_cmd` and `row_oe` are 0 and `row_addr` is 0.
- R2: A refresh request is generated at the INTERVAL-th rising edge after reset and then every INTERVAL edges. When the block is idle, the refresh starts on the following edge, so the first `ref_busy` is seen after edge INTERVAL+1.
- R3: Each refresh holds `ref_busy` high for exactly REF_LEN consecutive cycles.
- R4: In row-driven mode (`mode_cbr`=0), `row_oe` is 1, `ref_cmd` is 0 and `row_addr` equals the row counter for the whole refresh.
- R5: The row counter starts at 0 and advances by one after each row-driven refresh. It wraps from ROWS-1 to 0, so all ROWS rows are refreshed within ROWS*INTERVAL cycles.
- R6: In command-only mode (`mode_cbr`=1), `ref_cmd` is 1, `row_oe` is 0 and `row_addr` is 0 for the whole refresh, and the row counter does not change.
- R7: `mode_cbr` is sampled only on the edge a refresh starts. Changing it during a refresh does not alter that refresh's outputs.
- R8: When the block is idle with nothing pending, a high `host_req` gives `host_gnt`=1 after the next edge. `host_gnt` stays high until `host_done` is sampled high, then falls. `host_gnt` and `ref_busy` are never both high.
- R9: A pending refresh waits for the running host access to end. It then starts before any new host grant, even while `host_req` stays high.
- R10: Pending refreshes are counted up to PEND_MAX (8). Requests beyond that limit are dropped. The backlog is then served one refresh after another, with one idle cycle between them.
- R11: Under continuous short host accesses, no refresh request is lost: the number of refreshes started equals the number of requests generated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cbr | input | 1 | 1: command-only refresh, 0: row-driven refresh |
| host_req | input | 1 | Host wants the memory |
| host_done | input | 1 | Host ends its granted access |
| host_gnt | output | 1 | Host owns the memory |
| ref_busy | output | 1 | Refresh in progress |
| ref_cmd | output | 1 | Refresh command strobe (command-only mode) |
| row_oe | output | 1 | Row address lines driven |
| row_addr | output | $clog2(ROWS) | Row to refresh (row-driven mode), else 0 |

## Verification
The bench runs with a shortened interval and 16 rows. It walks the row counter through its wrap and checks that every row is seen inside one full window; a counter that wraps at the wrong place or skips a row leaves a hole in that set. It holds a host access across twelve intervals to force saturation of the pending count. A counter with no saturation, or one that drops requests it should keep, changes the total number of refreshes. It also checks that a refresh runs before the next grant. It switches to command-only mode and then back, and expects the row sequence to resume where it stopped, so a counter that keeps stepping in command-only mode is caught. It also flips the mode in the middle of a refresh to catch a design that decodes the mode combinationally.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int INTERVAL = 780,
  parameter int ROWS     = 8192,
  parameter int REF_LEN  = 8,
  parameter int PEND_MAX = 8,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int TW      = $clog2(INTERVAL + 1),
  localparam int LW      = $clog2(REF_LEN + 1),
  localparam int PW      = $clog2(PEND_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_cbr,
  input  logic             host_req,
  input  logic             host_done,
  output logic             host_gnt,
  output logic             ref_busy,
  output logic             ref_cmd,
  output logic             row_oe,
  output logic [ROW_W-1:0] row_addr
);

  typedef enum logic [1:0] {S_IDLE, S_HOST, S_REF} st_t;

  st_t              st_q;
  logic [TW-1:0]    tmr_q;
  logic [PW-1:0]    pend_q;
  logic [LW-1:0]    dur_q;
  logic [ROW_W-1:0] row_q;
  logic             mode_q;

  logic tick, start_ref, start_host, pend_inc;

  assign tick       = (tmr_q == '0);
  assign start_ref  = (st_q == S_IDLE) && (pend_q != '0);
  assign start_host = (st_q == S_IDLE) && (pend_q == '0) && host_req;
  assign pend_inc   = tick && ((pend_q != PW'(PEND_MAX)) || start_ref);

  always_ff @(posedge clk) begin
    if (!rst_n) tmr_q <= TW'(INTERVAL - 1);
    else        tmr_q <= tick ? TW'(INTERVAL - 1) : tmr_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend_q <= '0;
    else if (pend_inc && !start_ref)
      pend_q <= pend_q + 1'b1;
    else if (!pend_inc && start_ref)
      pend_q <= pend_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      dur_q  <= '0;
      mode_q <= 1'b0;
      row_q  <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (start_ref) begin
            st_q   <= S_REF;
            dur_q  <= LW'(REF_LEN - 1);
            mode_q <= mode_cbr;
          end else if (start_host) begin
            st_q <= S_HOST;
          end
        end
        S_HOST: if (host_done) st_q <= S_IDLE;
        S_REF: begin
          if (dur_q == '0) begin
            st_q <= S_IDLE;
            if (!mode_q)
              row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
          end else begin
            dur_q <= dur_q - 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ref_busy = (st_q == S_REF);
  assign host_gnt = (st_q == S_HOST);
  assign ref_cmd  = ref_busy && mode_q;
  assign row_oe   = ref_busy && !mode_q;
  assign row_addr = row_oe ? row_q : '0;

endmodule

module dram_refresh_sched_chk #(
  parameter int REF_LEN  = 8,
  parameter int PEND_MAX = 8,
  parameter int ROW_W    = 13,
  parameter int PW       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_gnt,
  input logic             ref_busy,
  input logic             ref_cmd,
  input logic             row_oe,
  input logic [ROW_W-1:0] row_addr,
  input logic [PW-1:0]    pend
);
  localparam int RW = $clog2(REF_LEN + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= ref_busy ? run_q + 1'b1 : '0;
  end

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_gnt && ref_busy));

  p_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_busy) |-> run_q == RW'(REF_LEN));

  p_len_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(REF_LEN));

  p_style_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> (row_oe ^ ref_cmd));

  p_undriven_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !row_oe |-> row_addr == '0);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_busy && $past(ref_busy)) |-> ($stable(row_oe) && $stable(row_addr)));

  p_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_gnt) |-> $past(pend) == '0);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(PEND_MAX));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .REF_LEN(REF_LEN), .PEND_MAX(PEND_MAX), .ROW_W(ROW_W), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_gnt(host_gnt), .ref_busy(ref_busy),
  .ref_cmd(ref_cmd), .row_oe(row_oe), .row_addr(row_addr), .pend(pend_q)
);

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
  localparam int I     = 40;
  localparam int ROWS  = 16;
  localparam int RLEN  = 3;
  localparam int PMAX  = 8;
  localparam int RW    = $clog2(ROWS);
  localparam int H     = I / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_cbr = 1'b0, host_req = 1'b0, host_done = 1'b0;
  logic host_gnt, ref_busy, ref_cmd, row_oe;
  logic [RW-1:0] row_addr;

  always #2 clk = ~clk;

  dram_refresh_sched #(.INTERVAL(I), .ROWS(ROWS), .REF_LEN(RLEN), .PEND_MAX(PMAX))
    i_dram_refresh_sched (
      .clk(clk), .rst_n(rst_n), .mode_cbr(mode_cbr), .host_req(host_req),
      .host_done(host_done), .host_gnt(host_gnt), .ref_busy(ref_busy),
      .ref_cmd(ref_cmd), .row_oe(row_oe), .row_addr(row_addr));

  int checks = 0, fails = 0, cyc = 0, starts = 0, grants = 0, run = 0;
  int next_row = 0;
  logic prev_busy = 1'b0, prev_gnt = 1'b0;
  logic [ROWS-1:0] seen = '0;
  logic [RW:0] expq[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_ref(input int n, input bit cbr);
    for (int k = 0; k < n; k++) begin
      if (cbr) expq.push_back({1'b1, RW'(0)});
      else begin
        expq.push_back({1'b0, RW'(next_row)});
        next_row = (next_row + 1) % ROWS;
      end
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (host_gnt && !prev_gnt) grants++;
      if (ref_busy && !prev_busy) begin
        logic [RW:0] e;
        starts++;
        run = 1;
        if (expq.size() == 0) begin
          check(1'b0, "R2 unexpected refresh", starts, starts - 1);
        end else begin
          e = expq.pop_front();
          if (e[RW]) begin
            check(ref_cmd == 1'b1, "R6 ref_cmd", ref_cmd, 1);
            check(row_oe == 1'b0, "R6 row_oe", row_oe, 0);
            check(row_addr == '0, "R6 row_addr", row_addr, 0);
          end else begin
            check(row_oe == 1'b1 && ref_cmd == 1'b0, "R4 strobes", {row_oe, ref_cmd}, 2);
            check(row_addr == e[RW-1:0], "R5 row", row_addr, e[RW-1:0]);
            seen[row_addr] = 1'b1;
          end
        end
      end else if (ref_busy) begin
        run++;
      end else if (prev_busy) begin
        check(run == RLEN, "R3 busy length", run, RLEN);
      end
      prev_busy = ref_busy;
      prev_gnt  = host_gnt;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int h;
    repeat (3) @(negedge clk);
    check(!ref_busy && !host_gnt && !ref_cmd && !row_oe && row_addr == '0,
          "R1 reset outputs", {ref_busy, host_gnt, ref_cmd, row_oe}, 0);
    expect_ref(20, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ref_busy && !host_gnt && !row_oe && row_addr == '0, "R1 after reset",
          {ref_busy, host_gnt, row_oe}, 0);

    wait_cyc(I);
    check(ref_busy == 1'b0, "R2 before first", ref_busy, 0);
    wait_cyc(I + 1);
    check(ref_busy == 1'b1, "R2 first refresh", ref_busy, 1);

    wait_cyc(16 * I + H);
    check(starts == 16, "R5 window count", starts, 16);
    check(&seen, "R5 all rows", $countones(seen), ROWS);

    wait_cyc(18 * I + 1);
    check(ref_busy == 1'b1, "R7 in refresh", ref_busy, 1);
    mode_cbr = 1'b1;
    wait_cyc(18 * I + 2);
    check(row_oe == 1'b1 && ref_cmd == 1'b0, "R7 mode held", {row_oe, ref_cmd}, 2);
    mode_cbr = 1'b0;

    wait_cyc(20 * I + H);
    check(expq.size() == 0, "R5 phase one drained", expq.size(), 0);
    expect_ref(10, 1'b0);
    host_req = 1'b1;
    h = 0;
    while (cyc < 30 * I + 2 || host_gnt || host_done) begin
      @(negedge clk);
      if (cyc >= 30 * I + 2) host_req = 1'b0;
      if (host_done) begin host_done = 1'b0; h = 0; end
      else if (host_gnt) begin h++; if (h == 2) host_done = 1'b1; end
    end
    wait_cyc(30 * I + H);
    check(starts == 30, "R11 no lost refresh", starts, 30);
    check(grants > 20, "R8 host served", grants, 21);

    expect_ref(11, 1'b0);
    host_req = 1'b1;
    @(negedge clk);
    check(host_gnt == 1'b1 && ref_busy == 1'b0, "R8 grant next edge", host_gnt, 1);
    wait_cyc(42 * I + H);
    check(host_gnt == 1'b1, "R8 grant held", host_gnt, 1);
    host_done = 1'b1;
    @(negedge clk);
    host_done = 1'b0;
    check(host_gnt == 1'b0 && ref_busy == 1'b0, "R8 grant released", {host_gnt, ref_busy}, 0);
    @(negedge clk);
    check(ref_busy == 1'b1 && host_gnt == 1'b0, "R9 refresh first", {ref_busy, host_gnt}, 2);
    host_req = 1'b0;
    wait_cyc(45 * I + H);
    check(starts == 41, "R10 saturated count", starts, 41);

    mode_cbr = 1'b1;
    expect_ref(5, 1'b1);
    wait_cyc(50 * I + H);
    check(starts == 46, "R6 cbr count", starts, 46);
    mode_cbr = 1'b0;
    expect_ref(3, 1'b0);
    wait_cyc(53 * I + H);
    check(starts == 49, "R6 total count", starts, 49);
    check(expq.size() == 0, "R6 queue empty", expq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule